// File: doc/BRIEF.md
# Pipelined 4x4 Matrix Multiplier

The block multiplies two square matrices of unsigned 8-bit numbers that sit in an external single-port synchronous RAM. The RAM has one cycle of read latency. A one-cycle start pulse, for example from a debounced push button, makes a controller issue one RAM read per clock. Each returned word is captured into an operand register file one cycle after its address was issued.

Once every operand has been captured, the block sends the result positions through a two-stage pipeline, one position per clock. The first stage forms the four 8x8 products and registers them. The second stage adds the four products and writes the 18-bit unsigned sum into a result register. When the last sum is written, a one-cycle done flag rises. The results then stay readable through a combinational read port until the next run overwrites them.

Both operands are stored column-major: element (row r, column c) sits at offset c*4+r. The left operand A starts at RAM address 0x00 and the right operand B at address 0x10. The result at row i, column j is read at index i*4+j.

Top module: `matmul4_core`

## Requirements
- R1: A synchronous reset, active high, leaves done at 0, mem_en at 0 and every result index reading 0. No RAM read occurs until a new start is sampled.
- R2: A start sampled in idle causes exactly 32 RAM reads on 32 consecutive clocks. The addresses run 0x00 to 0x0F for A, then 0x10 to 0x1F for B. mem_en is high only on those clocks.
- R3: Operands are column-major: A(r,c) is the word at address c*4+r, and B(r,c) is the word at address 0x10+c*4+r. The word for an address is taken from mem_rdata on the clock after that address was presented.
- R4: Each result equals the sum over k of A(i,k)*B(k,j), held as an 18-bit unsigned value with no loss, even when all operands are 255 (result 260100).
- R5: The result at row i, column j is returned on rd_data when rd_idx = i*4+j.
- R6: done is high for exactly one clock. It rises after the 50th rising edge that follows the edge that sampled start: 33 load cycles, 16 issue cycles and 1 drain cycle.
- R7: A start that arrives while the block is loading, computing, draining or showing done has no effect. No extra reads occur, the timing of done is unchanged, and no second done follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a multiplication |
| mem_en | output | 1 | RAM read enable |
| mem_addr | output | 8 | RAM read address |
| mem_rdata | input | 8 | RAM read data, valid the clock after the address |
| done | output | 1 | One-cycle flag: all 16 results are written |
| rd_idx | input | 4 | Result index, row-major i*4+j |
| rd_data | output | 18 | Result at rd_idx |

## Verification
A start request can land in the same cycle as the done pulse, when the controller is about to return to idle. It can also land during the load or compute phases. The bench raises start in mid-load and again in exactly the cycle where done is high. It then judges by the ports: the read count must stay at 32, done must keep its 50-cycle latency, and neither a new burst of reads nor a second done may follow. Inside the datapath, every issue cycle overlaps the previous position's sum write. An identity matrix for A and sweeps of distinct operand patterns expose any mix-up between that overlap and the index mapping.

// File: rtl/matmul4_pkg.sv
package matmul4_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_COMP  = 3'd2,
    ST_DRAIN = 3'd3,
    ST_DONE  = 3'd4
  } mm_state_e;

  // Width that holds a sum of dim products of two ew-bit unsigned values.
  function automatic int acc_width(input int ew, input int dim);
    return 2 * ew + $clog2(dim);
  endfunction

endpackage

// File: rtl/matmul4_ctrl.sv
module matmul4_ctrl
  import matmul4_pkg::*;
#(
  parameter int DIM    = 4,
  parameter int AW     = 8,
  parameter int A_BASE = 0,
  parameter int B_BASE = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  output logic                         mem_en,
  output logic [AW-1:0]                mem_addr,
  output logic                         cap_v,
  output logic [$clog2(2*DIM*DIM)-1:0] cap_idx,
  output logic                         iss_v,
  output logic [$clog2(DIM*DIM)-1:0]   iss_idx,
  output logic                         done
);
  localparam int N   = DIM * DIM;
  localparam int TOT = 2 * N;
  localparam int TW  = $clog2(TOT);
  localparam int IW  = $clog2(N);
  localparam int CW  = $clog2(TOT + 1);

  mm_state_e     state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      cap_v   <= 1'b0;
      cap_idx <= '0;
    end else begin
      cap_v   <= mem_en;
      cap_idx <= cnt[TW-1:0];
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_LOAD;
          cnt   <= '0;
        end
        ST_LOAD: if (cnt == CW'(TOT)) begin
          state <= ST_COMP;
          cnt   <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
        ST_COMP: if (cnt == CW'(N - 1)) begin
          state <= ST_DRAIN;
          cnt   <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
        ST_DRAIN: state <= ST_DONE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_en   = (state == ST_LOAD) && (cnt < CW'(TOT));
    mem_addr = (cnt < CW'(N)) ? AW'(A_BASE) + AW'(cnt)
                              : AW'(B_BASE) + AW'(cnt - CW'(N));
    iss_v    = (state == ST_COMP);
    iss_idx  = cnt[IW-1:0];
    done     = (state == ST_DONE);
  end

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_en_only_load_R2: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> state == ST_LOAD);
  assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_en && $past(mem_en) && $past(cnt) != CW'(N - 1)) |-> mem_addr == $past(mem_addr) + AW'(1));
  assert_done_to_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |=> state == ST_IDLE);
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> !(state == ST_LOAD && cnt == '0));

endmodule

// File: rtl/matmul4_opstore.sv
module matmul4_opstore #(
  parameter int DIM = 4,
  parameter int EW  = 8
) (
  input  logic                         clk,
  input  logic                         cap_v,
  input  logic [$clog2(2*DIM*DIM)-1:0] cap_idx,
  input  logic [EW-1:0]                wdata,
  input  logic [$clog2(DIM*DIM)-1:0]   iss_idx,
  output logic [DIM*EW-1:0]            a_vec,
  output logic [DIM*EW-1:0]            b_vec
);
  // DIM must be a power of two: operand offsets are built by bit concatenation.
  localparam int TOT = 2 * DIM * DIM;
  localparam int LW  = $clog2(DIM);

  logic [EW-1:0] ops [TOT];
  logic [LW-1:0] row_i, col_j;

  always_ff @(posedge clk) begin
    if (cap_v) ops[cap_idx] <= wdata;
  end

  assign row_i = iss_idx[2*LW-1:LW];
  assign col_j = iss_idx[LW-1:0];

  for (genvar k = 0; k < DIM; k++) begin : g_k
    localparam logic [LW-1:0] KB = LW'(k);
    // A(i,k) at k*DIM+i, B(k,j) at N + j*DIM+k (column-major).
    assign a_vec[k*EW +: EW] = ops[{1'b0, KB, row_i}];
    assign b_vec[k*EW +: EW] = ops[{1'b1, col_j, KB}];
  end

endmodule

// File: rtl/matmul4_pipe.sv
module matmul4_pipe #(
  parameter int DIM = 4,
  parameter int EW  = 8,
  parameter int ACC = 18
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       iss_v,
  input  logic [$clog2(DIM*DIM)-1:0] iss_idx,
  input  logic [DIM*EW-1:0]          a_vec,
  input  logic [DIM*EW-1:0]          b_vec,
  input  logic [$clog2(DIM*DIM)-1:0] rd_idx,
  output logic [ACC-1:0]             rd_data
);
  localparam int N  = DIM * DIM;
  localparam int IW = $clog2(N);
  localparam int PW = 2 * EW;
  localparam int SW = ACC + 1;

  function automatic logic [SW-1:0] sum_products(input logic [DIM*PW-1:0] pv);
    logic [SW-1:0] acc;
    acc = '0;
    for (int k = 0; k < DIM; k++) acc = acc + SW'(pv[k*PW +: PW]);
    return acc;
  endfunction

  logic [DIM*PW-1:0] prod;
  logic              s1_v;
  logic [IW-1:0]     s1_idx;
  logic [SW-1:0]     sum_w;
  logic [ACC-1:0]    res [N];

  // Stage 1: DIM multipliers, products registered.
  always_ff @(posedge clk) begin
    if (rst) begin
      prod   <= '0;
      s1_v   <= 1'b0;
      s1_idx <= '0;
    end else begin
      for (int k = 0; k < DIM; k++)
        prod[k*PW +: PW] <= a_vec[k*EW +: EW] * b_vec[k*EW +: EW];
      s1_v   <= iss_v;
      s1_idx <= iss_idx;
    end
  end

  // Stage 2: adder tree into the result registers.
  assign sum_w = sum_products(prod);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < N; n++) res[n] <= '0;
    end else if (s1_v) begin
      res[s1_idx] <= sum_w[ACC-1:0];
    end
  end

  assign rd_data = res[rd_idx];

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    s1_v |-> sum_w[SW-1] == 1'b0);
  assert_write_order_R5: assert property (@(posedge clk) disable iff (rst)
    (s1_v && $past(s1_v)) |-> s1_idx == $past(s1_idx) + IW'(1));

endmodule

// File: rtl/matmul4_core.sv
module matmul4_core
  import matmul4_pkg::*;
#(
  parameter int DIM    = 4,
  parameter int EW     = 8,
  parameter int AW     = 8,
  parameter int A_BASE = 0,
  parameter int B_BASE = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start,
  output logic                              mem_en,
  output logic [AW-1:0]                     mem_addr,
  input  logic [EW-1:0]                     mem_rdata,
  output logic                              done,
  input  logic [$clog2(DIM*DIM)-1:0]        rd_idx,
  output logic [acc_width(EW, DIM)-1:0]     rd_data
);
  localparam int N   = DIM * DIM;
  localparam int TW  = $clog2(2 * N);
  localparam int IW  = $clog2(N);
  localparam int ACC = acc_width(EW, DIM);

  logic              cap_v, iss_v;
  logic [TW-1:0]     cap_idx;
  logic [IW-1:0]     iss_idx;
  logic [DIM*EW-1:0] a_vec, b_vec;

  matmul4_ctrl #(.DIM(DIM), .AW(AW), .A_BASE(A_BASE), .B_BASE(B_BASE)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .mem_en(mem_en), .mem_addr(mem_addr),
    .cap_v(cap_v), .cap_idx(cap_idx), .iss_v(iss_v), .iss_idx(iss_idx), .done(done)
  );

  matmul4_opstore #(.DIM(DIM), .EW(EW)) u_ops (
    .clk(clk), .cap_v(cap_v), .cap_idx(cap_idx), .wdata(mem_rdata),
    .iss_idx(iss_idx), .a_vec(a_vec), .b_vec(b_vec)
  );

  matmul4_pipe #(.DIM(DIM), .EW(EW), .ACC(ACC)) u_pipe (
    .clk(clk), .rst(rst), .iss_v(iss_v), .iss_idx(iss_idx), .a_vec(a_vec),
    .b_vec(b_vec), .rd_idx(rd_idx), .rd_data(rd_data)
  );

endmodule

// File: tb/matmul4_core_bench.sv
module matmul4_core_bench;
  localparam int CLK_P = 10;
  localparam int N     = 16;
  localparam int LAT   = 3 * N + 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        mem_en;
  logic [7:0]  mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        done;
  logic [3:0]  rd_idx = '0;
  logic [17:0] rd_data;

  logic [7:0]  ram [32];
  int          checks = 0, fails = 0;
  int          en_seen = 0, bad_addr = 0, exp_addr = 0;
  bit          finished = 0;

  always #(CLK_P/2) clk = ~clk;

  matmul4_core u_matmul4_core (
    .clk(clk), .rst(rst), .start(start), .mem_en(mem_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .done(done), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  // RAM model: one cycle of read latency.
  always @(posedge clk) if (mem_en) mem_rdata <= ram[mem_addr[4:0]];

  // Read monitor, sampled between edges.
  always @(negedge clk) begin
    if (mem_en) begin
      if (int'(mem_addr) != exp_addr) bad_addr++;
      exp_addr++;
      en_seen++;
    end
  end

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int a_el(input int r, input int c);
    return int'(ram[c * 4 + r]);
  endfunction
  function automatic int b_el(input int r, input int c);
    return int'(ram[16 + c * 4 + r]);
  endfunction

  task automatic fill(input int p);
    for (int a = 0; a < 32; a++) begin
      if (p == 0)      ram[a] = 8'd0;
      else if (p == 1) ram[a] = 8'd255;
      else if (p == 2) ram[a] = (a < 16) ? ((a % 5 == 0) ? 8'd1 : 8'd0) : 8'(a * 7 + 3);
      else             ram[a] = 8'((a * 37 + p * 101 + a * a * p) ^ (p << 3));
    end
  endtask

  task automatic run(input int p, input bit poke);
    int cyc;
    fill(p);
    en_seen = 0; bad_addr = 0; exp_addr = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
      start = (poke && cyc == 10) ? 1'b1 : 1'b0;
      if (poke && done) start = 1'b1;   // start in the done cycle (R7)
    end
    check(cyc == LAT, "R6 latency", cyc, LAT);
    @(negedge clk) start = 1'b0;
    check(done == 1'b0, "R6 done width", int'(done), 0);
    repeat (5) begin
      @(negedge clk);
      check(done == 1'b0, "R7 no second done", int'(done), 0);
    end
    check(en_seen == 32, "R2 read count", en_seen, 32);
    check(bad_addr == 0, "R2 address order", bad_addr, 0);
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        int e = 0;
        for (int k = 0; k < 4; k++) e += a_el(i, k) * b_el(k, j);
        rd_idx = 4'(i * 4 + j);
        #1;
        check(int'(rd_data) == e, "R4/R5/R3 result", int'(rd_data), e);
        if (p == 1) check(int'(rd_data) == 260100, "R4 max value", int'(rd_data), 260100);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0 && mem_en == 1'b0, "R1 reset outputs", int'({done, mem_en}), 0);
    rst = 1'b0;
    for (int n = 0; n < 16; n++) begin
      rd_idx = 4'(n);
      #1;
      check(rd_data == '0, "R1 result cleared", int'(rd_data), 0);
    end
    repeat (3) @(negedge clk);
    check(en_seen == 0, "R1 no read before start", en_seen, 0);

    for (int p = 0; p < 24; p++) run(p, (p % 4) == 3);

    // Reset in the middle of a load.
    en_seen = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(mem_en == 1'b0 && done == 1'b0, "R1 mid-run reset", int'({mem_en, done}), 0);
    rd_idx = 4'd9;
    #1;
    check(rd_data == '0, "R1 results cleared by reset", int'(rd_data), 0);
    rst = 1'b0;
    en_seen = 0;
    repeat (60) @(negedge clk);
    check(en_seen == 0 && done == 1'b0, "R1 idle after reset", en_seen, 0);

    // One more run after the reset.
    run(77, 1'b0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule